// File: doc/BRIEF.md
# Interrupt Combiner and Priority Router

This block gathers 128 level-sensitive interrupt event lines and turns them into twelve prioritized requests toward a processor core, one for each core level from 4 to 15. Level 4 is the most urgent and level 15 the least. Levels 0 to 3 belong to reset, the non-maskable interrupt and two reserved slots, so the block never drives them. Each event line sets a sticky flag. Software clears a flag by writing 1 to its bit.

The events fall into four groups of 32. Each group has a combiner that ORs its flagged events that are not masked into one line. A per-combiner map register sends that line to one core level. Apart from the combiners, a twelve-entry routing table can send any single event numbered 4 to 127 straight to one core level. Entry k of the table drives level k+4, and the event mask does not apply to it. Event numbers 0 to 3 name the combiner outputs themselves, so those raw input lines are never used, and a table entry holding 0 to 3 routes nothing. A level that receives both a combiner and a direct route takes the OR of the two. The requests are registered. A combinational encoder reports the most urgent pending level.

Software reaches the block through a simple register port. Writes take effect at the clock edge, and reads return data in the same cycle.

Top module: `irq_combine_router`

## Requirements
- R1: An active event input e (4 to 127) sets flag bit e%32 of combiner e/32. The bit stays set after the input drops and can be read at address 0x00+e/32.
- R2: Writing a value to address 0x04+c clears the flag bits of combiner c where the value has a 1. An event that is active in the same cycle keeps its bit set.
- R3: Event inputs 0 to 3 never set a flag and never cause a request.
- R4: Mask register c (address 0x08+c, reset 0) stops every event whose bit is set from reaching the combined output of combiner c. The flag is still recorded, and clearing the mask bit lets the pending flag through.
- R5: Map register c (address 0x0C+c, 4 bits, reset 12+c) sends combiner c to core level equal to its value. A value below 4 sends it to no level.
- R6: Route entry k (address 0x10+k, 7 bits, reset 0) with a value v from 4 to 127 drives level k+4 from the flag of event v, whatever the mask. A value from 0 to 3 routes nothing.
- R7: When a combiner and a route entry target the same level, the request is the OR of both sources.
- R8: Output bit coreReq[k] is the request for core level k+4. It is registered, so an event present before a clock edge shows on coreReq right after that edge.
- R9: hiValid is 1 when any request is active. hiLevel then gives the lowest-numbered active level (4 to 15), and it is 0 when nothing is pending.
- R10: After reset all flags, masks and route entries are 0, the map registers hold 12 to 15, and all requests are low.
- R11: Reads of any address other than the flag, mask, map and route registers return 0. Writes to the flag addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 128 | Level-sensitive event inputs |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| coreReq | output | 12 | Request per core level, bit k is level k+4 |
| hiValid | output | 1 | Some level is pending |
| hiLevel | output | 4 | Most urgent pending level |

## Verification
The assertions check on every cycle that flags capture events and stay set, that a flag drops only when a clear write occurs, that inputs 0 to 3 never flag, that the requests fall idle when nothing is flagged, and that the encoder output agrees with the request vector. Only the bench scenarios can show how each register setting steers a flag to a level: masking, map values below 4, route entries 0 to 3, two sources merging on one level, and set winning over clear in the same cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_COMB     = 4;
  localparam int EVT_PER_COMB = 32;
  localparam int NUM_EVT      = NUM_COMB * EVT_PER_COMB;
  localparam int EVT_IDX_W    = $clog2(NUM_EVT);
  localparam int NUM_LVL      = 12;
  localparam int FIRST_LVL    = 4;
  localparam int LVL_W        = $clog2(FIRST_LVL + NUM_LVL);
  localparam int MAP_RST_BASE = FIRST_LVL + NUM_LVL - NUM_COMB;
  localparam int DATA_W       = EVT_PER_COMB;
  localparam int ADDR_W       = 6;
  localparam int FLAG_BASE    = 0;
  localparam int CLR_BASE     = FLAG_BASE + NUM_COMB;
  localparam int MASK_BASE    = CLR_BASE + NUM_COMB;
  localparam int MAP_BASE     = MASK_BASE + NUM_COMB;
  localparam int MUX_BASE     = MAP_BASE + NUM_COMB;

  typedef struct packed {
    logic [NUM_COMB-1:0] clrStb;
    logic [NUM_COMB-1:0] maskStb;
    logic [NUM_COMB-1:0] mapStb;
    logic [NUM_LVL-1:0]  muxStb;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    if (regWe) begin
      for (int c = 0; c < NUM_COMB; c++) begin
        if (regAddr == ADDR_W'(CLR_BASE + c))  strobes.clrStb[c]  = 1'b1;
        if (regAddr == ADDR_W'(MASK_BASE + c)) strobes.maskStb[c] = 1'b1;
        if (regAddr == ADDR_W'(MAP_BASE + c))  strobes.mapStb[c]  = 1'b1;
      end
      for (int l = 0; l < NUM_LVL; l++) begin
        if (regAddr == ADDR_W'(MUX_BASE + l)) strobes.muxStb[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_router_dpath.sv
module irq_router_dpath
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_EVT-1:0]   evtIn,
  input  ctlStrobes_t          strobes,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic [NUM_EVT-1:0]   flagFlat,
  output logic [NUM_LVL-1:0]   coreReq,
  output logic                 hiValid,
  output logic [LVL_W-1:0]     hiLevel
);
  localparam logic [NUM_EVT-1:0] USABLE = {NUM_EVT{1'b1}} << NUM_COMB;

  logic [NUM_COMB-1:0][EVT_PER_COMB-1:0] flagQ, flagNext, maskQ, evtLive;
  logic [NUM_COMB-1:0][LVL_W-1:0]        mapQ;
  logic [NUM_LVL-1:0][EVT_IDX_W-1:0]     muxQ;
  logic [NUM_COMB-1:0]                   combOut;
  logic [NUM_EVT-1:0]                    flagNextFlat;
  logic [NUM_LVL-1:0]                    reqNext;

  assign evtLive      = evtIn & USABLE;
  assign flagNextFlat = flagNext;
  assign flagFlat     = flagQ;

  for (genvar c = 0; c < NUM_COMB; c++) begin : g_comb
    assign flagNext[c] = (flagQ[c] & ~(strobes.clrStb[c] ? regWdata : '0)) | evtLive[c];
    assign combOut[c]  = |(flagNext[c] & ~maskQ[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[c] <= '0;
        maskQ[c] <= '0;
        mapQ[c]  <= LVL_W'(MAP_RST_BASE + c);
      end else begin
        flagQ[c] <= flagNext[c];
        if (strobes.maskStb[c]) maskQ[c] <= regWdata;
        if (strobes.mapStb[c])  mapQ[c]  <= regWdata[LVL_W-1:0];
      end
    end
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic directHit, combHit;
    assign directHit = (muxQ[l] >= EVT_IDX_W'(NUM_COMB)) && flagNextFlat[muxQ[l]];
    always_comb begin
      combHit = 1'b0;
      for (int c = 0; c < NUM_COMB; c++)
        if (combOut[c] && mapQ[c] == LVL_W'(l + FIRST_LVL)) combHit = 1'b1;
    end
    assign reqNext[l] = directHit | combHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        muxQ[l]    <= '0;
        coreReq[l] <= 1'b0;
      end else begin
        if (strobes.muxStb[l]) muxQ[l] <= regWdata[EVT_IDX_W-1:0];
        coreReq[l] <= reqNext[l];
      end
    end
  end

  always_comb begin
    hiValid = 1'b0;
    hiLevel = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (coreReq[l]) begin
        hiValid = 1'b1;
        hiLevel = LVL_W'(l + FIRST_LVL);
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int c = 0; c < NUM_COMB; c++) begin
      if (regAddr == ADDR_W'(FLAG_BASE + c)) regRdata = flagQ[c];
      if (regAddr == ADDR_W'(MASK_BASE + c)) regRdata = maskQ[c];
      if (regAddr == ADDR_W'(MAP_BASE + c))  regRdata = DATA_W'(mapQ[c]);
    end
    for (int l = 0; l < NUM_LVL; l++)
      if (regAddr == ADDR_W'(MUX_BASE + l)) regRdata = DATA_W'(muxQ[l]);
  end
endmodule

// File: rtl/irq_combine_router.sv
module irq_combine_router
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_EVT-1:0]   evtIn,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic [NUM_LVL-1:0]   coreReq,
  output logic                 hiValid,
  output logic [LVL_W-1:0]     hiLevel
);
  ctlStrobes_t        strobes;
  logic [NUM_EVT-1:0] flagFlat;

  irq_router_ctrl i_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irq_router_dpath i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .evtIn    (evtIn),
    .strobes  (strobes),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .flagFlat (flagFlat),
    .coreReq  (coreReq),
    .hiValid  (hiValid),
    .hiLevel  (hiLevel)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtIn,
  input logic               regWe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [NUM_EVT-1:0] flagFlat,
  input logic [NUM_LVL-1:0] coreReq,
  input logic               hiValid,
  input logic [LVL_W-1:0]   hiLevel
);
  localparam logic [NUM_EVT-1:0] USABLE = {NUM_EVT{1'b1}} << NUM_COMB;

  logic clrWrite;
  assign clrWrite = regWe && regAddr >= ADDR_W'(CLR_BASE) && regAddr < ADDR_W'(CLR_BASE + NUM_COMB);

  assert_evt_sets_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtIn & USABLE)) |=> ((flagFlat & $past(evtIn & USABLE)) == $past(evtIn & USABLE)));

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clrWrite |=> ((flagFlat & $past(flagFlat)) == $past(flagFlat)));

  assert_low_events_unused_R3: assert property (@(posedge clk) disable iff (!rstN)
    flagFlat[NUM_COMB-1:0] == '0);

  assert_idle_no_request_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flagFlat == '0 && (evtIn & USABLE) == '0) |=> coreReq == '0);

  assert_highest_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    hiValid |-> (coreReq[hiLevel - LVL_W'(FIRST_LVL)] &&
                 (coreReq & ((NUM_LVL'(1) << (hiLevel - LVL_W'(FIRST_LVL))) - NUM_LVL'(1))) == '0));

  assert_none_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hiValid |-> coreReq == '0);
endmodule

bind irq_combine_router irq_router_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtIn    (evtIn),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .flagFlat (flagFlat),
  .coreReq  (coreReq),
  .hiValid  (hiValid),
  .hiLevel  (hiLevel)
);

// File: tb/test_irq_combine_router.sv
module test_irq_combine_router;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] evtIn = '0;
  logic         regWe = 1'b0;
  logic [5:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic [11:0]  coreReq;
  logic         hiValid;
  logic [3:0]   hiLevel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_combine_router i_irq_combine_router (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .coreReq(coreReq),
    .hiValid(hiValid), .hiLevel(hiLevel)
  );

  // event number, expected coreReq, expected hiLevel (default config)
  localparam logic [22:0] VEC [6] = '{
    {7'd5,   12'h100, 4'd12},
    {7'd31,  12'h100, 4'd12},
    {7'd32,  12'h200, 4'd13},
    {7'd64,  12'h400, 4'd14},
    {7'd100, 12'h800, 4'd15},
    {7'd127, 12'h800, 4'd15}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; evtIn = '0; regWe = 1'b0; regAddr = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulse(input int e);
    @(negedge clk);
    evtIn[e] = 1'b1;
    @(negedge clk);
    evtIn[e] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    doReset();
    // R10 reset state
    chk("R10 coreReq", 32'(coreReq), 0);
    chk("R10 hiValid", 32'(hiValid), 0);
    for (int c = 0; c < 4; c++) begin
      rd(6'(12 + c), d); chk("R10 map", d, 32'(12 + c));
    end
    rd(6'h10, d); chk("R10 route", d, 0);
    rd(6'h08, d); chk("R10 mask", d, 0);
    rd(6'h00, d); chk("R10 flag", d, 0);

    // R8 / R9 table walk with default config
    for (int v = 0; v < 6; v++) begin
      doReset();
      pulse(int'(VEC[v][22:16]));
      chk("R8 level", 32'(coreReq), 32'(VEC[v][15:4]));
      chk("R9 hiLevel", 32'(hiLevel), 32'(VEC[v][3:0]));
      chk("R9 hiValid", 32'(hiValid), 1);
    end

    // R3 low events ignored
    doReset();
    pulse(2); pulse(3);
    rd(6'h00, d); chk("R3 flag", d, 0);
    chk("R3 coreReq", 32'(coreReq), 0);

    // R1 sticky flag
    doReset();
    pulse(40);
    repeat (3) @(negedge clk);
    rd(6'h01, d); chk("R1 flag", d, 32'h100);

    // R2 clear: set wins, then clears
    @(negedge clk); evtIn[40] = 1'b1;
    wr(6'h05, 32'h100);
    rd(6'h01, d); chk("R2 set wins", d, 32'h100);
    evtIn[40] = 1'b0;
    wr(6'h05, 32'h100);
    rd(6'h01, d); chk("R2 cleared", d, 0);
    chk("R2 coreReq", 32'(coreReq), 0);

    // R4 mask
    doReset();
    wr(6'h09, 32'h100);
    pulse(40);
    chk("R4 masked", 32'(coreReq), 0);
    rd(6'h01, d); chk("R4 flag kept", d, 32'h100);
    wr(6'h09, 32'h0);
    @(negedge clk);
    chk("R4 unmasked", 32'(coreReq), 32'h200);

    // R6 direct route ignores mask
    doReset();
    wr(6'h09, 32'h1);
    wr(6'h14, 32);
    rd(6'h14, d); chk("R6 route read", d, 32);
    pulse(32);
    chk("R6 direct", 32'(coreReq), 32'h010);
    chk("R6 hiLevel", 32'(hiLevel), 8);
    // R6 entry value below 4 routes nothing
    doReset();
    wr(6'h10, 32'd3);
    wr(6'h08, 32'h20);
    pulse(5);
    chk("R6 no route", 32'(coreReq), 0);

    // R7 OR of combiner and direct route
    doReset();
    wr(6'h0C, 32'd8);
    wr(6'h09, 32'h1);
    wr(6'h14, 32);
    pulse(10);
    chk("R7 comb", 32'(coreReq), 32'h010);
    pulse(32);
    wr(6'h04, 32'h400);
    chk("R7 direct holds", 32'(coreReq), 32'h010);
    wr(6'h05, 32'h1);
    chk("R7 both cleared", 32'(coreReq), 0);

    // R5 map and R9 priority
    doReset();
    wr(6'h0E, 32'd5);
    pulse(70);
    chk("R5 map", 32'(coreReq), 32'h002);
    pulse(40);
    chk("R9 two levels", 32'(coreReq), 32'h202);
    chk("R9 lowest", 32'(hiLevel), 5);
    wr(6'h0F, 32'd2);
    pulse(100);
    chk("R5 below 4", 32'(coreReq), 32'h202);

    // R11 flag write ignored, unmapped read zero
    doReset();
    wr(6'h01, 32'hFFFF_FFFF);
    rd(6'h01, d); chk("R11 flag write", d, 0);
    rd(6'h3F, d); chk("R11 unmapped", d, 0);
    rd(6'h05, d); chk("R11 clear addr", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule